// File: doc/BRIEF.md
# Accumulator Execute Stage with Selective Flag Update

This block is the execute step of a small 8-bit accumulator core. Each accepted operation carries a 5-bit opcode, the accumulator value, a second operand and the current carry flag. The second operand is either an immediate or a RAM byte that the core has already fetched. The block returns the 8-bit result, the new zero and carry values, and four write strobes. The strobes tell the core whether to write the result to the accumulator or back to the RAM byte, and whether to update each flag. The binary operations (or, and, xor, add-with-carry) target the accumulator. The unary operations (increment, decrement, rotate right through carry) are read-modify-write operations on memory. Every opcode outside these two groups passes through with all strobes low.

Operations enter on a valid/ready interface and leave one cycle later through a registered valid/ready interface. The input is ready whenever the output register is empty or is being drained in the same cycle, so a full-rate stream moves one operation per cycle. When the consumer holds `out_ready` low while `out_valid` is high, the result and its strobes stay frozen and `in_ready` drops. No operation is lost or duplicated. The opcode field is split as `op[4:3]` (group) and `op[2:0]` (selector). Only selectors with `op[2]`=0 do arithmetic or logic.

Top module: `alu_exec_stage`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Opcodes 01_000/11_000 (or), 01_001/11_001 (and) and 01_010/11_010 (xor) produce the bitwise result of `in_acc` and `in_opnd`. They raise `out_we_acc` and `out_we_z`, and keep `out_we_c` and `out_we_mem` low.
- R3: Opcodes 01_011 and 11_011 produce `in_acc + in_opnd + in_carry` modulo 256, with `out_c` equal to the carry out. They raise `out_we_acc`, `out_we_z` and `out_we_c`. For example, 0x00 + 0x0F with carry 1 gives 0x10 with `out_c`=0.
- R4: Opcode 10_000 produces `in_opnd + 1`. It raises `out_we_mem`, `out_we_z` and `out_we_c`, and `out_c` is 1 only when the operand was 0xFF.
- R5: Opcode 10_001 produces `in_opnd - 1`. It raises `out_we_mem`, `out_we_z` and `out_we_c`, and `out_c` is the borrow, which is 1 only when the operand was 0x00.
- R6: Opcode 10_011 produces `{in_carry, in_opnd[7:1]}`. It raises `out_we_mem`, `out_we_z` and `out_we_c`, and `out_c` equals `in_opnd[0]`.
- R7: Whenever `out_we_z` is 1, `out_z` is 1 exactly when `out_result` is zero.
- R8: Opcode 10_010 and every opcode with `op[2]`=1 or `op[4:3]`=00 raise no strobe.
- R9: An operation is taken when `in_valid` and `in_ready` are both 1. `in_ready` equals `!out_valid || out_ready`, and the result shows on the output in the cycle after the operation is taken, in order.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output fields stay unchanged on the next cycle and `in_ready` is 0.
- R11: `out_we_acc` and `out_we_mem` are never both 1, and any result write comes with `out_we_z`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Stage can take an operation |
| in_op | input | 5 | Opcode, group in [4:3], selector in [2:0] |
| in_acc | input | 8 | Accumulator value |
| in_opnd | input | 8 | Immediate or RAM byte |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 8 | Computed byte |
| out_z | output | 1 | New zero flag |
| out_c | output | 1 | New carry flag |
| out_we_acc | output | 1 | Write result to accumulator |
| out_we_mem | output | 1 | Write result back to RAM byte |
| out_we_z | output | 1 | Update zero flag |
| out_we_c | output | 1 | Update carry flag |

## Verification
The stage can take a new operation in the same cycle that it hands the previous result to the consumer. This is the case where the registered output is reloaded as it is drained. The bench provokes it with a long run of operations while `out_ready` is held high, and then with `out_ready` toggled pseudo-randomly. Each result must come out exactly once and in order, and a stalled result must stay frozen until it is taken. A scoreboard holds the expected value for every issued operation and checks this.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  localparam int OP_W = 5;

  typedef enum logic [2:0] {
    K_NONE,
    K_LOGIC,
    K_ADC,
    K_INC,
    K_DEC,
    K_ROR
  } op_kind_e;

  typedef enum logic [1:0] {
    LG_OR,
    LG_AND,
    LG_XOR
  } logic_sel_e;

  typedef struct packed {
    op_kind_e   kind;
    logic_sel_e lsel;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_exec_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output alu_ctrl_t       ctrl
);

  logic [1:0] grp;
  logic [1:0] sel;
  logic       arith;

  assign grp   = op[4:3];
  assign sel   = op[1:0];
  assign arith = ~op[2];

  always_comb begin
    ctrl.kind = K_NONE;
    ctrl.lsel = LG_OR;
    if (arith) begin
      unique case (grp)
        2'b01, 2'b11: begin
          unique case (sel)
            2'b00:   begin ctrl.kind = K_LOGIC; ctrl.lsel = LG_OR;  end
            2'b01:   begin ctrl.kind = K_LOGIC; ctrl.lsel = LG_AND; end
            2'b10:   begin ctrl.kind = K_LOGIC; ctrl.lsel = LG_XOR; end
            default: ctrl.kind = K_ADC;
          endcase
        end
        2'b10: begin
          unique case (sel)
            2'b00:   ctrl.kind = K_INC;
            2'b01:   ctrl.kind = K_DEC;
            2'b11:   ctrl.kind = K_ROR;
            default: ctrl.kind = K_NONE;
          endcase
        end
        default: ctrl.kind = K_NONE;
      endcase
    end
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_exec_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_ctrl_t       ctrl,
  input  logic [DW-1:0]   acc,
  input  logic [DW-1:0]   opnd,
  input  logic            cin,
  output logic [DW-1:0]   res,
  output logic            cout
);

  localparam logic [DW:0] ONE_X = (DW+1)'(1);

  logic [DW-1:0] lres;
  logic [DW:0]   adc_w;
  logic [DW:0]   inc_w;
  logic [DW:0]   dec_w;

  for (genvar i = 0; i < DW; i++) begin : g_lbit
    assign lres[i] = (ctrl.lsel == LG_OR)  ? (acc[i] | opnd[i]) :
                     (ctrl.lsel == LG_AND) ? (acc[i] & opnd[i]) :
                                             (acc[i] ^ opnd[i]);
  end

  assign adc_w = {1'b0, acc} + {1'b0, opnd} + {{DW{1'b0}}, cin};
  assign inc_w = {1'b0, opnd} + ONE_X;
  assign dec_w = {1'b0, opnd} - ONE_X;

  always_comb begin
    res  = '0;
    cout = 1'b0;
    unique case (ctrl.kind)
      K_LOGIC: res = lres;
      K_ADC:   begin res = adc_w[DW-1:0]; cout = adc_w[DW]; end
      K_INC:   begin res = inc_w[DW-1:0]; cout = inc_w[DW]; end
      K_DEC:   begin res = dec_w[DW-1:0]; cout = dec_w[DW]; end
      K_ROR:   begin res = {cin, opnd[DW-1:1]}; cout = opnd[0]; end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_exec_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_ctrl_t     ctrl,
  input  logic [DW-1:0] res,
  input  logic          cout,
  output logic          z_new,
  output logic          c_new,
  output logic          we_acc,
  output logic          we_mem,
  output logic          we_z,
  output logic          we_c
);

  always_comb begin
    we_acc = (ctrl.kind == K_LOGIC) || (ctrl.kind == K_ADC);
    we_mem = (ctrl.kind == K_INC) || (ctrl.kind == K_DEC) || (ctrl.kind == K_ROR);
    we_z   = we_acc || we_mem;
    we_c   = (ctrl.kind == K_ADC) || we_mem;
    z_new  = we_z && (res == '0);
    c_new  = we_c && cout;
  end

endmodule

// File: rtl/alu_exec_stage.sv
module alu_exec_stage
  import alu_exec_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_op,
  input  logic [DW-1:0]   in_acc,
  input  logic [DW-1:0]   in_opnd,
  input  logic            in_carry,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_result,
  output logic            out_z,
  output logic            out_c,
  output logic            out_we_acc,
  output logic            out_we_mem,
  output logic            out_we_z,
  output logic            out_we_c
);

  alu_ctrl_t     ctrl;
  logic [DW-1:0] res_d;
  logic          cout_d;
  logic          z_d, c_d, wa_d, wm_d, wz_d, wc_d;
  logic          take;

  alu_decode u_dec (
    .op   (in_op),
    .ctrl (ctrl)
  );

  alu_datapath #(.DW(DW)) u_dp (
    .ctrl (ctrl),
    .acc  (in_acc),
    .opnd (in_opnd),
    .cin  (in_carry),
    .res  (res_d),
    .cout (cout_d)
  );

  alu_flags #(.DW(DW)) u_flg (
    .ctrl   (ctrl),
    .res    (res_d),
    .cout   (cout_d),
    .z_new  (z_d),
    .c_new  (c_d),
    .we_acc (wa_d),
    .we_mem (wm_d),
    .we_z   (wz_d),
    .we_c   (wc_d)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_z      <= 1'b0;
      out_c      <= 1'b0;
      out_we_acc <= 1'b0;
      out_we_mem <= 1'b0;
      out_we_z   <= 1'b0;
      out_we_c   <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_result <= res_d;
        out_z      <= z_d;
        out_c      <= c_d;
        out_we_acc <= wa_d;
        out_we_mem <= wm_d;
        out_we_z   <= wz_d;
        out_we_c   <= wc_d;
      end
    end
  end

endmodule

// File: rtl/alu_exec_stage_chk.sv
module alu_exec_stage_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_result,
  input logic          out_z,
  input logic          out_c,
  input logic          out_we_acc,
  input logic          out_we_mem,
  input logic          out_we_z,
  input logic          out_we_c
);

  assert_reset_empty_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_take_shows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_z)
      && $stable(out_c) && $stable(out_we_acc) && $stable(out_we_mem)
      && $stable(out_we_z) && $stable(out_we_c));

  assert_stall_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_one_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_we_acc && out_we_mem));

  assert_write_sets_z_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_we_acc || out_we_mem) |-> out_we_z);

  assert_unary_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_we_mem |-> out_we_c);

endmodule

bind alu_exec_stage alu_exec_stage_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_z      (out_z),
  .out_c      (out_c),
  .out_we_acc (out_we_acc),
  .out_we_mem (out_we_mem),
  .out_we_z   (out_we_z),
  .out_we_c   (out_we_c)
);

// File: tb/alu_exec_stage_bench.sv
module alu_exec_stage_bench;

  typedef struct {
    logic [7:0] res;
    logic       z, c, wa, wm, wz, wc;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [4:0] in_op = '0;
  logic [7:0] in_acc = '0;
  logic [7:0] in_opnd = '0;
  logic       in_carry = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_result;
  logic       out_z, out_c, out_we_acc, out_we_mem, out_we_z, out_we_c;

  int   total = 0;
  int   bad = 0;
  int   rdy_mode = 0;
  bit   finished = 0;
  exp_t sb[$];

  always #5 clk = ~clk;

  alu_exec_stage u_alu_exec_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_acc(in_acc), .in_opnd(in_opnd), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_z(out_z), .out_c(out_c), .out_we_acc(out_we_acc), .out_we_mem(out_we_mem),
    .out_we_z(out_we_z), .out_we_c(out_we_c)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [4:0] op, input logic [7:0] a,
                                 input logic [7:0] b, input logic ci);
    exp_t e;
    logic [8:0] w;
    e.res = 8'h00; e.c = 1'b0; e.wa = 0; e.wm = 0; e.wz = 0; e.wc = 0; e.tag = "R8";
    case (op)
      5'b01000, 5'b11000: begin e.res = a | b; e.wa = 1; e.wz = 1; e.tag = "R2"; end
      5'b01001, 5'b11001: begin e.res = a & b; e.wa = 1; e.wz = 1; e.tag = "R2"; end
      5'b01010, 5'b11010: begin e.res = a ^ b; e.wa = 1; e.wz = 1; e.tag = "R2"; end
      5'b01011, 5'b11011: begin
        w = 9'(a) + 9'(b) + 9'(ci);
        e.res = w[7:0]; e.c = w[8]; e.wa = 1; e.wz = 1; e.wc = 1; e.tag = "R3";
      end
      5'b10000: begin e.res = b + 8'd1; e.c = (b == 8'hFF); e.wm = 1; e.wz = 1; e.wc = 1; e.tag = "R4"; end
      5'b10001: begin e.res = b - 8'd1; e.c = (b == 8'h00); e.wm = 1; e.wz = 1; e.wc = 1; e.tag = "R5"; end
      5'b10011: begin e.res = {ci, b[7:1]}; e.c = b[0]; e.wm = 1; e.wz = 1; e.wc = 1; e.tag = "R6"; end
      default: ;
    endcase
    e.z = e.wz && (e.res == 8'h00);
    return e;
  endfunction

  task automatic send(input logic [4:0] op, input logic [7:0] a,
                      input logic [7:0] b, input logic ci);
    sb.push_back(model(op, a, b, ci));
    @(negedge clk); #1;
    in_valid = 1'b1; in_op = op; in_acc = a; in_opnd = b; in_carry = ci;
    #1;
    while (!in_ready) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // out_ready pattern
  initial begin
    forever begin
      @(negedge clk); #1;
      out_ready = (rdy_mode == 0) ? 1'b1 : (($urandom % 4) != 0);
    end
  end

  // scoreboard monitor
  initial begin
    bit         prev_stall = 0;
    logic [7:0] prev_res = '0;
    exp_t       e;
    forever begin
      @(negedge clk); #3;
      if (rst_n) begin
        if (prev_stall) begin
          chk("R10 held result", int'(out_result), int'(prev_res));
          chk("R10 still valid", int'(out_valid), 1);
        end
        if (out_valid && !out_ready) chk("R10 in_ready low on stall", int'(in_ready), 0);
        if (out_valid && out_ready) begin
          if (sb.size() == 0) chk("R9 unexpected result", 1, 0);
          else begin
            e = sb.pop_front();
            chk({e.tag, " we_acc"}, int'(out_we_acc), int'(e.wa));
            chk({e.tag, " we_mem"}, int'(out_we_mem), int'(e.wm));
            chk({e.tag, " we_z"},   int'(out_we_z),   int'(e.wz));
            chk({e.tag, " we_c"},   int'(out_we_c),   int'(e.wc));
            if (e.wa || e.wm) chk({e.tag, " result"}, int'(out_result), int'(e.res));
            if (e.wz) chk("R7 zero flag", int'(out_z), int'(e.z));
            if (e.wc) chk({e.tag, " carry"}, int'(out_c), int'(e.c));
            chk("R11 single target", int'(out_we_acc && out_we_mem), 0);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_res   = out_result;
      end
    end
  end

  // watchdog
  initial begin
    #(150000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 in_ready in reset", int'(in_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 in_ready after reset", int'(in_ready), 1);

    // back-to-back with consumer always ready: accept and drain in one cycle
    send(5'b01000, 8'h50, 8'h0A, 1'b0);   // R2 or -> 5A
    send(5'b11001, 8'hF0, 8'h0F, 1'b1);   // R2 and -> 00, Z
    send(5'b01010, 8'hAA, 8'hAA, 1'b0);   // R2 xor -> 00
    send(5'b01011, 8'h00, 8'h0F, 1'b1);   // R3 -> 10, C=0
    send(5'b11011, 8'hFF, 8'h01, 1'b0);   // R3 -> 00, C=1, Z
    send(5'b10000, 8'h33, 8'hFF, 1'b0);   // R4 -> 00, C=1
    send(5'b10000, 8'h00, 8'h7F, 1'b1);   // R4 -> 80, C=0
    send(5'b10001, 8'h00, 8'h00, 1'b0);   // R5 -> FF, borrow
    send(5'b10001, 8'h00, 8'h01, 1'b1);   // R5 -> 00, Z
    send(5'b10011, 8'h00, 8'h01, 1'b0);   // R6 -> 00, C=1
    send(5'b10011, 8'h00, 8'h80, 1'b1);   // R6 -> C0, C=0
    send(5'b10010, 8'h12, 8'h34, 1'b1);   // R8 reserved
    send(5'b00000, 8'h12, 8'h34, 1'b1);   // R8
    send(5'b01100, 8'h12, 8'h34, 1'b0);   // R8
    send(5'b11111, 8'h12, 8'h34, 1'b0);   // R8
    send(5'b10111, 8'h12, 8'h34, 1'b1);   // R8

    for (int i = 0; i < 150; i++)
      send(5'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));

    rdy_mode = 1;   // back-pressure, R9 ordering and R10 holding
    for (int i = 0; i < 250; i++)
      send(5'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));

    for (int i = 0; i < 2000 && sb.size() != 0; i++) @(negedge clk);
    chk("R9 all results drained", sb.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule